// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This unit is the computing element of a single-bus processor datapath. Each operation takes its operands from three 16-bit sources: the A operand latch, the AH high-half latch and the B bus value. A 4-bit function code selects the operation, and a 5-bit shift count is used by the shift operations. The unit writes a 16-bit low result register C and a 16-bit high result register CH. A sequencer pulses `start` with the operands and the function code held steady. It then waits for `done` before it moves the results onto the bus.

Every function except division completes in the cycle after `start`. Multiplication produces a 32-bit unsigned product: the high half goes to CH and the low half to C. Division takes the 32-bit dividend AH:A and the 16-bit divisor B. It runs one quotient bit per cycle, asserts `busy` while it works, and writes the quotient to C and the remainder to CH. A divisor of zero, or a dividend whose quotient would not fit in 16 bits, raises an error flag and leaves both result registers untouched.

Top module: `alsu_unit`

## Requirements
- R1: While `rst_n` is low, `c_out`, `ch_out`, `busy`, `done` and `div_err` are all zero.
- R2: Function 0 (add) gives C = A + B. Function 1 (subtract) gives C = A - B. Both wrap modulo 2^16.
- R3: Function 4 gives A AND B and function 5 gives A OR B. Function 6 gives the complement of B, function 10 passes B through unchanged, and function 11 gives B + 2 modulo 2^16.
- R4: Functions 7 (left), 8 (logical right) and 9 (arithmetic right) shift B by `shamt`, which ranges from 0 to 31. A count of 16 or more yields all zeros, except for the arithmetic right shift, which yields 16 copies of B[15].
- R5: Function 2 multiplies A and B as unsigned numbers, with {CH, C} = A * B.
- R6: Function 3 divides {AH, A} by B when B is nonzero and AH < B. `busy` is high for exactly 16 cycles after the start edge. `done` then pulses together with C = quotient and CH = remainder, and `div_err` is low.
- R7: A divide with B = 0, or with AH >= B, raises `div_err` and `done` in the next cycle. It never raises `busy`, and it leaves C and CH unchanged.
- R8: A non-divide start drives `done` high in the next cycle, with the result in place and `busy` low. CH changes only on multiply or divide. Function codes 12 to 15 leave both C and CH unchanged.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The divide result is not disturbed.
- R10: `div_err` holds until the next accepted start, and any accepted operation that is not a failing divide clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the selected operation |
| func | input | 4 | Function code |
| a_in | input | 16 | A operand, low half of the dividend |
| ah_in | input | 16 | High half of the dividend |
| b_in | input | 16 | Bus operand, divisor |
| shamt | input | 5 | Shift count |
| c_out | output | 16 | Low result register |
| ch_out | output | 16 | High result register |
| busy | output | 1 | Divide in progress |
| done | output | 1 | Result ready pulse |
| div_err | output | 1 | Divide by zero or quotient overflow |

## Verification
The bench aims at the shift counts where the barrel stages run out: 0, 15, 16 and 31, with a negative operand. A shifter that truncated the count to four bits would return B unshifted at 16 and would fill with the wrong bit. It checks division at AH = B - 1 and at AH = B, where a wrong overflow test would either reject a legal quotient or return a truncated one, and it checks that a divide by zero leaves C and CH unchanged. A start pulse injected in the middle of a divide tests that the quotient survives, and the bench counts the `busy` cycles so that an off-by-one iteration counter shows up as a wrong length and a wrong quotient. It also confirms that a plain operation leaves CH alone and clears a stale error flag.

// File: rtl/alsu_pkg.sv
package alsu_pkg;
  typedef enum logic [3:0] {
    FN_ADD  = 4'd0,
    FN_SUB  = 4'd1,
    FN_MUL  = 4'd2,
    FN_DIV  = 4'd3,
    FN_AND  = 4'd4,
    FN_OR   = 4'd5,
    FN_NOT  = 4'd6,
    FN_SHL  = 4'd7,
    FN_SHR  = 4'd8,
    FN_ASR  = 4'd9,
    FN_PASS = 4'd10,
    FN_INC2 = 4'd11
  } alsu_fn_e;
endpackage

// File: rtl/alsu_shifter.sv
module alsu_shifter #(
  parameter int W  = 16,
  parameter int SW = 5
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          right,
  input  logic          arith,
  output logic [W-1:0]  dout
);
  logic [SW:0][W-1:0] stg;
  logic               fill;

  assign fill   = right & arith & din[W-1];
  assign stg[0] = din;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int D = 1 << s;
    if (D >= W) begin : g_full
      assign stg[s+1] = !amt[s] ? stg[s] : {W{fill}};
    end else begin : g_part
      logic [W-1:0] lft, rgt;
      assign lft = {stg[s][W-1-D:0], {D{1'b0}}};
      assign rgt = {{D{fill}}, stg[s][W-1:D]};
      assign stg[s+1] = !amt[s] ? stg[s] : (right ? rgt : lft);
    end
  end

  assign dout = stg[SW];
endmodule

// File: rtl/alsu_core.sv
module alsu_core
  import alsu_pkg::*;
#(
  parameter int W  = 16,
  parameter int SW = 5
) (
  input  logic [3:0]    func,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [SW-1:0] shamt,
  output logic [W-1:0]  c_res,
  output logic [W-1:0]  ch_res,
  output logic          c_wr,
  output logic          ch_wr
);
  localparam int PW = 2 * W;

  logic [W-1:0]  sh_res;
  logic [PW-1:0] prod;
  logic          sh_right, sh_arith;

  assign sh_right = (func == FN_SHR) || (func == FN_ASR);
  assign sh_arith = (func == FN_ASR);
  assign prod     = {{W{1'b0}}, a} * {{W{1'b0}}, b};

  alsu_shifter #(.W(W), .SW(SW)) u_shift (
    .din  (b),
    .amt  (shamt),
    .right(sh_right),
    .arith(sh_arith),
    .dout (sh_res)
  );

  always_comb begin
    c_res  = '0;
    ch_res = '0;
    c_wr   = 1'b1;
    ch_wr  = 1'b0;
    unique case (func)
      FN_ADD:  c_res = a + b;
      FN_SUB:  c_res = a - b;
      FN_MUL: begin
        c_res  = prod[W-1:0];
        ch_res = prod[PW-1:W];
        ch_wr  = 1'b1;
      end
      FN_AND:  c_res = a & b;
      FN_OR:   c_res = a | b;
      FN_NOT:  c_res = ~b;
      FN_SHL,
      FN_SHR,
      FN_ASR:  c_res = sh_res;
      FN_PASS: c_res = b;
      FN_INC2: c_res = b + W'(2);
      default: c_wr  = 1'b0;
    endcase
  end
endmodule

// File: rtl/alsu_divider.sv
module alsu_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] dvs,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quo_nx,
  output logic [W-1:0] rem_nx
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d, quo_q, quo_d, dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic [W:0]    r_sh, trial;
  logic          ge;

  assign r_sh   = {rem_q, quo_q[W-1]};
  assign ge     = r_sh >= {1'b0, dvs_q};
  assign trial  = r_sh - {1'b0, dvs_q};
  assign rem_nx = ge ? trial[W-1:0] : r_sh[W-1:0];
  assign quo_nx = {quo_q[W-2:0], ge};
  assign fin    = busy_q && (cnt_q == CW'(1));
  assign busy   = busy_q;

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (go && !busy_q) begin
      rem_d  = dvd_hi;
      quo_d  = dvd_lo;
      dvs_d  = dvs;
      cnt_d  = CW'(W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d  = rem_nx;
      quo_d  = quo_nx;
      cnt_d  = cnt_q - CW'(1);
      busy_d = !fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/alsu_unit.sv
module alsu_unit
  import alsu_pkg::*;
#(
  parameter int W  = 16,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    func,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  ah_in,
  input  logic [W-1:0]  b_in,
  input  logic [SW-1:0] shamt,
  output logic [W-1:0]  c_out,
  output logic [W-1:0]  ch_out,
  output logic          busy,
  output logic          done,
  output logic          div_err
);
  logic [W-1:0] c_q, c_d, ch_q, ch_d;
  logic         done_q, done_d, err_q, err_d;
  logic [W-1:0] core_c, core_ch, quo_nx, rem_nx;
  logic         core_cwr, core_chwr;
  logic         div_busy, div_fin, accept, is_div, div_bad, div_go;

  assign accept  = start && !div_busy;
  assign is_div  = (func == FN_DIV);
  assign div_bad = (b_in == '0) || (ah_in >= b_in);
  assign div_go  = accept && is_div && !div_bad;

  alsu_core #(.W(W), .SW(SW)) u_core (
    .func  (func),
    .a     (a_in),
    .b     (b_in),
    .shamt (shamt),
    .c_res (core_c),
    .ch_res(core_ch),
    .c_wr  (core_cwr),
    .ch_wr (core_chwr)
  );

  alsu_divider #(.W(W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .dvd_hi(ah_in),
    .dvd_lo(a_in),
    .dvs   (b_in),
    .busy  (div_busy),
    .fin   (div_fin),
    .quo_nx(quo_nx),
    .rem_nx(rem_nx)
  );

  always_comb begin
    c_d    = c_q;
    ch_d   = ch_q;
    err_d  = err_q;
    done_d = 1'b0;
    if (accept) begin
      err_d  = is_div && div_bad;
      done_d = !div_go;
      if (!is_div) begin
        if (core_cwr)  c_d  = core_c;
        if (core_chwr) ch_d = core_ch;
      end
    end
    if (div_fin) begin
      c_d    = quo_nx;
      ch_d   = rem_nx;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q    <= '0;
      ch_q   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      c_q    <= c_d;
      ch_q   <= ch_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign c_out   = c_q;
  assign ch_out  = ch_q;
  assign done    = done_q;
  assign div_err = err_q;
  assign busy    = div_busy;
endmodule

// File: rtl/alsu_unit_chk.sv
module alsu_unit_chk
  import alsu_pkg::*;
#(
  parameter int W  = 16,
  parameter int SW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [3:0]    func,
  input logic [W-1:0]  a_in,
  input logic [W-1:0]  ah_in,
  input logic [W-1:0]  b_in,
  input logic [SW-1:0] shamt,
  input logic [W-1:0]  c_out,
  input logic [W-1:0]  ch_out,
  input logic          busy,
  input logic          done,
  input logic          div_err
);
  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R6
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && func != FN_DIV) |=> (done && !busy));

  // R8
  ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && func != FN_DIV && func != FN_MUL) |=> $stable(ch_out));

  // R7
  div_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && func == FN_DIV && (b_in == '0 || ah_in >= b_in))
      |=> (div_err && done && !busy && $stable(c_out) && $stable(ch_out)));

  // R6
  div_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && func == FN_DIV && b_in != '0 && ah_in < b_in)
      |=> (busy && !div_err && !done));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(c_out) && $stable(ch_out)));
endmodule

bind alsu_unit alsu_unit_chk #(.W(W), .SW(SW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .func   (func),
  .a_in   (a_in),
  .ah_in  (ah_in),
  .b_in   (b_in),
  .shamt  (shamt),
  .c_out  (c_out),
  .ch_out (ch_out),
  .busy   (busy),
  .done   (done),
  .div_err(div_err)
);

// File: tb/alsu_unit_tb.sv
module alsu_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  func;
  logic [15:0] a_in, ah_in, b_in;
  logic [4:0]  shamt;
  logic [15:0] c_out, ch_out;
  logic        busy, done, div_err;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  alsu_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .func(func),
    .a_in(a_in), .ah_in(ah_in), .b_in(b_in), .shamt(shamt),
    .c_out(c_out), .ch_out(ch_out), .busy(busy), .done(done),
    .div_err(div_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_c(input logic [3:0] f, input logic [15:0] a,
                                        input logic [15:0] b, input logic [4:0] s,
                                        input logic [15:0] old);
    logic [31:0] p;
    p = {16'd0, a} * {16'd0, b};
    case (f)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return p[15:0];
      4'd4:  return a & b;
      4'd5:  return a | b;
      4'd6:  return ~b;
      4'd7:  return (s > 5'd15) ? 16'd0 : (b << s);
      4'd8:  return (s > 5'd15) ? 16'd0 : (b >> s);
      4'd9:  return (s > 5'd15) ? {16{b[15]}} : 16'($signed(b) >>> s);
      4'd10: return b;
      4'd11: return b + 16'd2;
      default: return old;
    endcase
  endfunction

  function automatic string tag(input logic [3:0] f);
    case (f)
      4'd0, 4'd1: return "R2";
      4'd2:       return "R5";
      4'd7, 4'd8, 4'd9: return "R4";
      4'd4, 4'd5, 4'd6, 4'd10, 4'd11: return "R3";
      default:    return "R8";
    endcase
  endfunction

  // non-divide operation: result checked one cycle after the start edge
  task automatic run_op(input logic [3:0] f, input logic [15:0] a, input logic [15:0] b,
                        input logic [4:0] s);
    logic [15:0] c_old, ch_old, exp_c, exp_ch;
    logic [31:0] p;
    @(negedge clk);
    c_old = c_out; ch_old = ch_out;
    func = f; a_in = a; b_in = b; shamt = s; ah_in = $urandom; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    p = {16'd0, a} * {16'd0, b};
    exp_c  = ref_c(f, a, b, s, c_old);
    exp_ch = (f == 4'd2) ? p[31:16] : ch_old;
    chk(c_out == exp_c, tag(f), {16'd0, c_out}, {16'd0, exp_c});
    chk(ch_out == exp_ch, (f == 4'd2) ? "R5" : "R8", {16'd0, ch_out}, {16'd0, exp_ch});
    chk(done && !busy && !div_err, "R8 R10", {29'd0, done, busy, div_err}, 32'd4);
  endtask

  task automatic run_div(input logic [15:0] ah, input logic [15:0] a, input logic [15:0] b,
                         input bit inject);
    logic [15:0] c_old, ch_old;
    logic [31:0] dvd;
    int n;
    @(negedge clk);
    c_old = c_out; ch_old = ch_out;
    func = 4'd3; a_in = a; ah_in = ah; b_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (b == 16'd0 || ah >= b) begin
      chk(div_err && done && !busy, "R7", {29'd0, div_err, done, busy}, 32'd6);
      chk(c_out == c_old && ch_out == ch_old, "R7", {c_out, ch_out}, {c_old, ch_old});
    end else begin
      n = 0;
      while (busy && n < 100) begin
        n++;
        if (inject && n == 3) begin
          func = 4'd0; a_in = 16'h1111; b_in = 16'h2222; start = 1'b1;
        end else begin
          start = 1'b0;
        end
        chk(!done, "R6", {31'd0, done}, 32'd0);
        @(negedge clk);
      end
      start = 1'b0;
      dvd = {ah, a};
      chk(n == 16, "R6", n, 16);
      chk(done && !div_err, "R6", {30'd0, done, div_err}, 32'd2);
      chk(c_out == 16'(dvd / {16'd0, b}), inject ? "R9" : "R6",
          {16'd0, c_out}, dvd / {16'd0, b});
      chk(ch_out == 16'(dvd % {16'd0, b}), inject ? "R9" : "R6",
          {16'd0, ch_out}, dvd % {16'd0, b});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0]  f;
    logic [15:0] a, b, ah;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; start = 1'b0; func = '0; a_in = '0; ah_in = '0; b_in = '0; shamt = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(c_out == 0 && ch_out == 0 && !busy && !done && !div_err, "R1",
        {c_out, ch_out}, 32'd0);
    rst_n = 1'b1;

    // directed corners
    run_op(4'd1, 16'h0000, 16'h0001, 5'd0);   // R2 wrap
    run_op(4'd0, 16'hFFFF, 16'h0002, 5'd0);   // R2 wrap
    run_op(4'd11, 16'h0000, 16'hFFFF, 5'd0);  // R3 INC2 wrap
    run_op(4'd6, 16'h0000, 16'h0F0F, 5'd0);   // R3
    run_op(4'd2, 16'hFFFF, 16'hFFFF, 5'd0);   // R5
    for (int k = 7; k <= 9; k++) begin
      run_op(4'(k), 16'h0, 16'h8421, 5'd0);   // R4 boundary counts
      run_op(4'(k), 16'h0, 16'h8421, 5'd15);
      run_op(4'(k), 16'h0, 16'h8421, 5'd16);
      run_op(4'(k), 16'h0, 16'h8421, 5'd31);
    end
    run_op(4'd13, 16'h1234, 16'h5678, 5'd3);  // R8 reserved code
    run_div(16'h0003, 16'h1234, 16'h0000, 1'b0); // R7 divide by zero
    run_op(4'd10, 16'h0, 16'hBEEF, 5'd0);        // R10 clears error
    run_div(16'h0100, 16'h0000, 16'h0100, 1'b0); // R7 AH == B
    run_div(16'h00FF, 16'hFFFF, 16'h0100, 1'b0); // R6 AH = B-1
    run_div(16'h0000, 16'h0007, 16'hFFFF, 1'b1); // R9 injected start

    // random mix
    for (int i = 0; i < 400; i++) begin
      f = 4'($urandom_range(0, 15));
      a = $urandom; b = $urandom;
      if (f == 4'd3) begin
        if ($urandom_range(0, 7) == 0) b = 16'd0;
        ah = (b == 0) ? 16'($urandom) : 16'($urandom_range(0, int'(b) - 1));
        run_div(ah, a, b, ($urandom_range(0, 3) == 0));
      end else begin
        run_op(f, a, b, 5'($urandom));
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule